// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a chipset a bank of byte-wide configuration registers that is reached through two I/O addresses on a simple synchronous bus. Software first writes a register number to the index port. It then reads or writes the chosen register through the data port. Each data access uses up the index. Software must write the index again before the next data access, even when it accesses the same register again. A data access that has no index written before it has no effect, and when it is a read it returns all ones.

The implemented register numbers form a contiguous window. Numbers outside the window are treated as absent. Some bits are fixed at a read-only value. Every register has a defined reset value. The whole bank is driven out in parallel to the decode logic that the registers control. Each accepted write also produces a one-cycle update strobe carrying the register number, so that this logic knows when to recompute. Two free scratch bytes sit at their own I/O addresses and need no index.

A two-state controller tracks whether the index is armed. The states are DISARMED and ARMED. The transitions are:
- ARM: an index write in DISARMED moves to ARMED.
- REARM: an index write in ARMED stays in ARMED.
- CONSUME: a data-port read or write in ARMED moves to DISARMED.
- REJECT: a data-port access in DISARMED stays in DISARMED and is ignored.

Top module: `cfg_index_port`

## Requirements
- R1: A write to I/O address 0x22 latches io_wdata as the register index and arms the data port. A further index write re-arms the port with the new value.
- R2: A write to I/O address 0x24 while the port is armed and the index lies in 0x20..0x2C updates that register. The new value appears on cfg_regs after the clock edge. Register 0x20+k occupies bits k*8+7..k*8.
- R3: A read of I/O address 0x24 while the port is armed and the index lies in the window loads that register's value onto io_rdata at the clock edge. io_rdata holds that value until the next read.
- R4: Any data-port access, read or write, disarms the port. A data write made while the port is disarmed changes no register and gives no update strobe. A data read made while the port is disarmed returns 0xFF.
- R5: With an armed index outside 0x20..0x2C, a data write changes no register and gives no strobe. A data read with such an index returns 0xFF. Both accesses still disarm the port.
- R6: Bits 7:6 of register 0x20 always read 2'b01, and writes do not change them. Bits 5:0 of register 0x20 are writable.
- R7: After reset, register 0x20 holds 0x40, register 0x22 holds 0x84, register 0x28 holds 0x80 and register 0x29 holds 0x10. Every other register holds 0x00. io_rdata is 0xFF, upd_pulse is 0 and the port is disarmed.
- R8: Scratch bytes at I/O addresses 0xE1 and 0xE2 reset to 0xFF. They are written and read directly, with no index. Scratch accesses neither arm nor disarm the data port.
- R9: Each accepted register write raises upd_pulse for exactly one cycle after the edge, with upd_index equal to the written index. upd_index holds its value until the next accepted write.
- R10: A read of any I/O address other than 0x24, 0xE1 and 0xE2 returns 0xFF. This includes the index port. Such a read does not disarm the port.
- R11: When io_wr and io_rd are both high in the same cycle, only the write is performed and io_rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered at the read edge |
| cfg_regs | output | NREG*8 | All configuration registers, lowest index in the lowest byte |
| upd_pulse | output | 1 | One-cycle strobe after an accepted register write |
| upd_index | output | 8 | Index of the last accepted register write |

## Verification
Two events can fall in the same clock edge. One is the update strobe raised by an accepted data write. The other is the next index write, which changes the latched index. The bench provokes this by issuing an index write in the cycle right after a data write, while upd_pulse is still high. It then checks that upd_index still reports the register that was written and not the new index. It also checks that the new index is armed and works.

A second overlap is a write and a read asserted together on the data port. It is judged by checking that the register takes the write data while io_rdata keeps its earlier value.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;

    function automatic logic [BYTE_W-1:0] reg_reset_value(input logic [BYTE_W-1:0] idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            8'h20:   v = 8'h40;
            8'h22:   v = 8'h84;
            8'h28:   v = 8'h80;
            8'h29:   v = 8'h10;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] reg_ro_mask(input logic [BYTE_W-1:0] idx);
        return (idx == 8'h20) ? 8'hC0 : 8'h00;
    endfunction

endpackage

// File: rtl/cfg_arm_fsm.sv
module cfg_arm_fsm
    import cfg_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idx_wr,
    input  logic data_acc,
    output logic armed,
    output logic accept
);

    arm_state_e state_q;
    arm_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DISARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: begin
                if (idx_wr) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (idx_wr) begin
                    state_d = ST_ARMED;
                end else if (data_acc) begin
                    state_d = ST_DISARMED;
                end
            end
        endcase
    end

    always_comb begin
        armed  = (state_q == ST_ARMED);
        accept = armed && data_acc;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_port_pkg::*;
#(
    parameter logic [BYTE_W-1:0] IDX_LO = 8'h20,
    parameter int                NREG   = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [BYTE_W-1:0]      widx,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [NREG*BYTE_W-1:0] regs
);

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam logic [BYTE_W-1:0] MY_IDX = BYTE_W'(int'(IDX_LO) + k);
        localparam logic [BYTE_W-1:0] RST_V  = reg_reset_value(MY_IDX);
        localparam logic [BYTE_W-1:0] RO_M   = reg_ro_mask(MY_IDX);
        logic [BYTE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= RST_V;
            end else if (we && (widx == MY_IDX)) begin
                q <= (wdata & ~RO_M) | (q & RO_M);
            end
        end

        assign regs[k*BYTE_W +: BYTE_W] = q;
    end

endmodule

// File: rtl/cfg_scratch.sv
module cfg_scratch
    import cfg_port_pkg::*;
#(
    parameter int NSCR = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSCR-1:0]        we,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [NSCR*BYTE_W-1:0] q
);

    for (genvar j = 0; j < NSCR; j++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[j*BYTE_W +: BYTE_W] <= '1;
            end else if (we[j]) begin
                q[j*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0024,
    parameter logic [ADDR_W-1:0] SCR_BASE  = 16'h00E1,
    parameter int                NSCR      = 2,
    parameter logic [7:0]        IDX_LO    = 8'h20,
    parameter logic [7:0]        IDX_HI    = 8'h2C,
    localparam int               NREG      = int'(IDX_HI) - int'(IDX_LO) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic [NREG*8-1:0]   cfg_regs,
    output logic                upd_pulse,
    output logic [7:0]          upd_index
);

    logic              idx_wr;
    logic              data_wr;
    logic              data_rd;
    logic              data_acc;
    logic              armed;
    logic              accept;
    logic              in_range;
    logic              bank_we;
    logic              rd_only;
    logic [BYTE_W-1:0] idx_q;
    logic [BYTE_W-1:0] rd_val;
    logic [NSCR-1:0]   scr_sel;
    logic [NSCR*BYTE_W-1:0] scr_q;

    assign rd_only  = io_rd && !io_wr;
    assign idx_wr   = io_wr && (io_addr == IDX_PORT);
    assign data_wr  = io_wr && (io_addr == DATA_PORT);
    assign data_rd  = rd_only && (io_addr == DATA_PORT);
    assign data_acc = data_wr || data_rd;
    assign in_range = (idx_q >= IDX_LO) && (idx_q <= IDX_HI);
    assign bank_we  = accept && data_wr && in_range;

    for (genvar j = 0; j < NSCR; j++) begin : g_sel
        assign scr_sel[j] = (io_addr == ADDR_W'(int'(SCR_BASE) + j));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= io_wdata;
        end
    end

    cfg_arm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .data_acc (data_acc),
        .armed    (armed),
        .accept   (accept)
    );

    cfg_reg_bank #(
        .IDX_LO (IDX_LO),
        .NREG   (NREG)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (idx_q),
        .wdata (io_wdata),
        .regs  (cfg_regs)
    );

    cfg_scratch #(
        .NSCR (NSCR)
    ) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (scr_sel & {NSCR{io_wr}}),
        .wdata (io_wdata),
        .q     (scr_q)
    );

    always_comb begin
        rd_val = '1;
        if ((io_addr == DATA_PORT) && accept && in_range) begin
            for (int k = 0; k < NREG; k++) begin
                if (idx_q == BYTE_W'(int'(IDX_LO) + k)) begin
                    rd_val = cfg_regs[k*BYTE_W +: BYTE_W];
                end
            end
        end
        for (int j = 0; j < NSCR; j++) begin
            if (scr_sel[j]) begin
                rd_val = scr_q[j*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata  <= '1;
            upd_pulse <= 1'b0;
            upd_index <= '0;
        end else begin
            if (rd_only) begin
                io_rdata <= rd_val;
            end
            upd_pulse <= bank_we;
            if (bank_we) begin
                upd_index <= idx_q;
            end
        end
    end

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0024,
    parameter logic [ADDR_W-1:0] SCR_BASE  = 16'h00E1,
    parameter logic [7:0]        IDX_LO    = 8'h20,
    parameter logic [7:0]        IDX_HI    = 8'h2C,
    parameter int                NREG      = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_rdata,
    input logic [NREG*8-1:0] cfg_regs,
    input logic              upd_pulse,
    input logic [7:0]        upd_index,
    input logic              armed
);

    assert_rev_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_regs[7:6] == 2'b01);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse);

    assert_pulse_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> ((upd_index >= IDX_LO) && (upd_index <= IDX_HI)));

    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |-> $stable(cfg_regs));

    assert_disarmed_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && (io_addr == DATA_PORT) && !armed) |=> (io_rdata == 8'hFF));

    assert_scratch_no_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == SCR_BASE)) |=> (armed == $past(armed)));

endmodule

bind cfg_index_port cfg_index_port_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_PORT (DATA_PORT),
    .SCR_BASE  (SCR_BASE),
    .IDX_LO    (IDX_LO),
    .IDX_HI    (IDX_HI),
    .NREG      (NREG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_rdata  (io_rdata),
    .cfg_regs  (cfg_regs),
    .upd_pulse (upd_pulse),
    .upd_index (upd_index),
    .armed     (armed)
);

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;

    localparam int NREG = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      io_addr = '0;
    logic             io_wr = 1'b0;
    logic             io_rd = 1'b0;
    logic [7:0]       io_wdata = '0;
    logic [7:0]       io_rdata;
    logic [NREG*8-1:0] cfg_regs;
    logic             upd_pulse;
    logic [7:0]       upd_index;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] m_regs [NREG];
    logic [7:0] m_scr [2];
    logic [7:0] m_idx;
    logic [7:0] m_rdata;
    logic [7:0] m_uidx;
    bit         m_arm;
    bit         m_pulse;

    always #5 clk = ~clk;

    cfg_index_port u_cfg_index_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .cfg_regs  (cfg_regs),
        .upd_pulse (upd_pulse),
        .upd_index (upd_index)
    );

    function automatic logic [7:0] dflt(int k);
        case (k)
            0: return 8'h40;
            2: return 8'h84;
            8: return 8'h80;
            9: return 8'h10;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] ro_mask(int k);
        return (k == 0) ? 8'hC0 : 8'h00;
    endfunction

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int k = 0; k < NREG; k++) f[k*8 +: 8] = m_regs[k];
        return f;
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; drives one access, applies the model, checks after the edge.
    task automatic do_op(logic [15:0] a, bit wr, bit rd, logic [7:0] wd, string tag);
        int k;
        m_pulse = 1'b0;
        if (wr) begin
            if (a == 16'h22) begin
                m_idx = wd;
                m_arm = 1'b1;
            end else if (a == 16'h24) begin
                if (m_arm && m_idx >= 8'h20 && m_idx <= 8'h2C) begin
                    k = int'(m_idx) - 32;
                    m_regs[k] = (wd & ~ro_mask(k)) | (m_regs[k] & ro_mask(k));
                    m_pulse = 1'b1;
                    m_uidx = m_idx;
                end
                m_arm = 1'b0;
            end else if (a == 16'hE1 || a == 16'hE2) begin
                m_scr[a - 16'hE1] = wd;
            end
        end else if (rd) begin
            m_rdata = 8'hFF;
            if (a == 16'h24) begin
                if (m_arm && m_idx >= 8'h20 && m_idx <= 8'h2C) m_rdata = m_regs[int'(m_idx) - 32];
                m_arm = 1'b0;
            end else if (a == 16'hE1 || a == 16'hE2) begin
                m_rdata = m_scr[a - 16'hE1];
            end
        end
        io_addr = a; io_wr = wr; io_rd = rd; io_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        check(cfg_regs == model_flat(), {tag, " R2 regs"}, cfg_regs, model_flat());
        check(upd_pulse == m_pulse, {tag, " R9 pulse"}, upd_pulse, m_pulse);
        if (m_pulse) check(upd_index == m_uidx, {tag, " R9 index"}, upd_index, m_uidx);
        check(io_rdata == m_rdata, {tag, " R3 rdata"}, io_rdata, m_rdata);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd7151);
        for (int k = 0; k < NREG; k++) m_regs[k] = dflt(k);
        m_scr[0] = 8'hFF; m_scr[1] = 8'hFF;
        m_idx = 8'h00; m_arm = 1'b0; m_rdata = 8'hFF; m_uidx = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset state
        check(cfg_regs == model_flat(), "R7 reset regs", cfg_regs, model_flat());
        check(io_rdata == 8'hFF, "R7 reset rdata", io_rdata, 8'hFF);
        check(upd_pulse == 1'b0, "R7 reset pulse", upd_pulse, 1'b0);
        do_op(16'h24, 0, 1, 8'h00, "R7 disarmed after reset");
        do_op(16'hE1, 0, 1, 8'h00, "R8 scratch reset E1");
        check(io_rdata == 8'hFF, "R8 scratch reset literal", io_rdata, 8'hFF);

        // R1 R2 R9 write, then R4 second write ignored
        do_op(16'h22, 1, 0, 8'h21, "R1 index");
        do_op(16'h24, 1, 0, 8'hA5, "R2 write 21");
        check(cfg_regs[15:8] == 8'hA5, "R2 literal reg21", cfg_regs[15:8], 8'hA5);
        do_op(16'h24, 1, 0, 8'h5A, "R4 second write");
        check(cfg_regs[15:8] == 8'hA5, "R4 literal reg21 kept", cfg_regs[15:8], 8'hA5);

        // R3 read then R4 second read
        do_op(16'h22, 1, 0, 8'h21, "R1 index again");
        do_op(16'h24, 0, 1, 8'h00, "R3 read 21");
        check(io_rdata == 8'hA5, "R3 literal read", io_rdata, 8'hA5);
        do_op(16'h24, 0, 1, 8'h00, "R4 second read");
        check(io_rdata == 8'hFF, "R4 literal FF", io_rdata, 8'hFF);

        // R5 out of range both sides
        do_op(16'h22, 1, 0, 8'h2D, "R5 index 2D");
        do_op(16'h24, 1, 0, 8'h33, "R5 write 2D");
        do_op(16'h22, 1, 0, 8'h1F, "R5 index 1F");
        do_op(16'h24, 0, 1, 8'h00, "R5 read 1F");
        do_op(16'h24, 1, 0, 8'h11, "R5 disarmed after out of range");

        // R6 read-only revision bits
        do_op(16'h22, 1, 0, 8'h20, "R6 index");
        do_op(16'h24, 1, 0, 8'h3F, "R6 write 3F");
        check(cfg_regs[7:0] == 8'h7F, "R6 literal 7F", cfg_regs[7:0], 8'h7F);
        do_op(16'h22, 1, 0, 8'h20, "R6 index");
        do_op(16'h24, 1, 0, 8'h80, "R6 write 80");
        check(cfg_regs[7:0] == 8'h40, "R6 literal 40", cfg_regs[7:0], 8'h40);

        // R8 scratch does not disturb arming; R10 unmapped reads
        do_op(16'hE2, 1, 0, 8'h12, "R8 scratch write");
        do_op(16'h22, 1, 0, 8'h2C, "R1 index 2C");
        do_op(16'hE1, 1, 0, 8'h34, "R8 scratch write while armed");
        do_op(16'h22, 0, 1, 8'h00, "R10 read index port");
        do_op(16'h0080, 0, 1, 8'h00, "R10 read unmapped");
        do_op(16'h24, 1, 0, 8'h9C, "R8 still armed write 2C");
        check(cfg_regs[12*8 +: 8] == 8'h9C, "R8 literal reg2C", cfg_regs[12*8 +: 8], 8'h9C);
        do_op(16'hE2, 0, 1, 8'h00, "R8 scratch read");
        check(io_rdata == 8'h12, "R8 literal scratch", io_rdata, 8'h12);

        // Overlap: index write in the cycle the strobe is high (R9, R1)
        do_op(16'h22, 1, 0, 8'h23, "R1 index 23");
        do_op(16'h24, 1, 0, 8'h66, "R9 write 23");
        io_addr = 16'h22; io_wr = 1'b1; io_wdata = 8'h25;
        check(upd_pulse == 1'b1 && upd_index == 8'h23, "R9 strobe during index", upd_index, 8'h23);
        m_idx = 8'h25; m_arm = 1'b1;
        @(posedge clk); @(negedge clk); io_wr = 1'b0;
        check(upd_pulse == 1'b0 && upd_index == 8'h23, "R9 index held", upd_index, 8'h23);
        do_op(16'h24, 1, 0, 8'h77, "R1 new index armed");
        check(upd_index == 8'h25, "R1 literal index 25", upd_index, 8'h25);

        // R11 write and read together
        do_op(16'h22, 1, 0, 8'h24, "R11 index");
        do_op(16'h24, 1, 1, 8'hC3, "R11 write and read");
        check(cfg_regs[4*8 +: 8] == 8'hC3, "R11 literal reg24", cfg_regs[4*8 +: 8], 8'hC3);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned sel;
            sel = $urandom % 6;
            case (sel)
                0: do_op(16'h22, 1, 0, 8'(8'h1C + ($urandom % 24)), "R1 rand index");
                1, 2: do_op(16'h24, 1, 0, 8'($urandom), "R2 rand write");
                3: do_op(16'h24, 0, 1, 8'h00, "R3 rand read");
                4: do_op(16'(16'hE1 + ($urandom % 2)), 1, 0, 8'($urandom), "R8 rand scratch write");
                default: do_op(16'(16'hE1 + ($urandom % 2)), 0, 1, 8'h00, "R8 rand scratch read");
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule